// File: doc/BRIEF.md
# Dual-Modulus Divide-by-8/9 Prescaler

This block divides a fast input clock by eight or by nine, picked by a single modulus-select input. It sits at the front of a pulse-swallow feedback divider, where an outer counter flips the modulus once per output period to set the overall ratio. Two stages are cascaded. A synchronous core running at the input rate divides by four or five. A divide-by-two stage advances on each completed core period and forms the output clock. In silicon that stage is a ripple flop. Here it is a clock-enabled flop in the same clock domain, so the whole block has a single clock.

The core stretches one of its periods from four to five cycles only while the divide-by-two stage is in its second half and the latched modulus asks for nine. So the extra cycle always falls in the high phase of the output. The modulus input is captured only on the edge that closes an output period. A change on the pin never shortens or lengthens a period that is already running. A one-cycle tick marks the first input cycle of every output period. All ports are plain control and clock pins with no data stream, so no valid/ready handshake applies.

Top module: `dmp_prescaler`

## Requirements
- R1: While the latched modulus is 0, consecutive `period_tick` pulses are exactly 8 input cycles apart.
- R2: While the latched modulus is 1, consecutive `period_tick` pulses are exactly 9 input cycles apart.
- R3: Each output period has `div_out` low for its first 4 input cycles and high for the rest, which is 4 cycles (ratio 8) or 5 cycles (ratio 9).
- R4: `mod_sel` is sampled only on the clock edge that ends an output period, and that value sets the length of the next period. Changes on `mod_sel` at any other edge do not alter the running period.
- R5: While `srst` is high at a clock edge, `div_out` and `period_tick` are 0 and `mod_sel` is loaded as the modulus for the first period.
- R6: After `srst` is released, the first `period_tick` goes high after the 8th clock edge (modulus 0) or the 9th clock edge (modulus 1) counted from the first edge with `srst` low.
- R7: `period_tick` is high for exactly one cycle. It is high in the first cycle of a period, while `div_out` is low.
- R8: The core adds its fifth cycle only when the latched modulus is 1 and the divide-by-two stage is high. It never adds two extra cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock; every flop runs on its rising edge |
| srst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | Modulus select: 0 divides by 8, 1 divides by 9 |
| div_out | output | 1 | Divided clock: low for 4 cycles, then high for 4 or 5 |
| period_tick | output | 1 | One-cycle pulse in the first input cycle of every output period |

## Verification
The block is driven with the modulus held at 0 and then held at 1. These runs separate the two ratios and show where the extra cycle sits inside the period. It is then driven with the modulus toggling on several strides: every cycle, every 3 cycles and every 7 cycles. These strides flip the pin inside a period, so a design that reacts mid-period produces interval lengths that differ from the value sampled at the boundary. A second reset part-way through the run, with the modulus held high, shows that the first period after release is a full 9 cycles and that stale expectations are flushed.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  // Structural ratios of the prescaler.
  localparam int CORE_LOW  = 4;              // short core period
  localparam int RATIO_LOW = 2 * CORE_LOW;   // overall low modulus
  localparam int RATIO_HI  = RATIO_LOW + 1;  // overall high modulus
  localparam int GAP_W     = $clog2(RATIO_HI + 1) + 1;

  // Core state: two Johnson flops plus one stretch flop.
  typedef struct packed {
    logic       stretch;
    logic [1:0] jc;
  } core_st_t;

  localparam logic [1:0] JC_LAST = 2'b10;
endpackage

// File: rtl/dmp_core45.sv
module dmp_core45
  import dmp_pkg::*;
(
  input  logic clk_in,
  input  logic srst,
  input  logic stretch_en,
  output logic wrap
);
  core_st_t st;
  logic     at_last;
  logic     take;

  assign at_last = (st.jc == JC_LAST) && !st.stretch;
  assign take    = at_last && stretch_en;
  // The core period closes on the last Johnson state, or on the stretch state.
  assign wrap    = st.stretch || (at_last && !stretch_en);

  // Stretch gating sits directly in each flop's next-state term.
  always_ff @(posedge clk_in) begin
    if (srst) begin
      st <= '0;
    end else begin
      st.stretch <= take;
      st.jc[1]   <= !st.stretch && (take || st.jc[0]);
      st.jc[0]   <= !st.stretch && !take && !st.jc[1];
    end
  end

  // R8: the stretch state is entered only after the enable was seen.
  assert_stretch_gated_R8: assert property (@(posedge clk_in) disable iff (srst)
    st.stretch |-> $past(stretch_en));
  // R8: never two stretch cycles back to back.
  assert_stretch_single_R8: assert property (@(posedge clk_in) disable iff (srst)
    st.stretch |=> !st.stretch);
endmodule

// File: rtl/dmp_half_stage.sv
module dmp_half_stage (
  input  logic clk_in,
  input  logic srst,
  input  logic adv,
  output logic half
);
  always_ff @(posedge clk_in) begin
    if (srst)     half <= 1'b0;
    else if (adv) half <= !half;
  end

  // R3: the divide-by-two stage moves only on a completed core period.
  assert_half_moves_on_wrap_R3: assert property (@(posedge clk_in) disable iff (srst)
    !$stable(half) |-> $past(adv));
endmodule

// File: rtl/dmp_mod_latch.sv
module dmp_mod_latch (
  input  logic clk_in,
  input  logic srst,
  input  logic capture,
  input  logic mod_in,
  output logic mod_q
);
  always_ff @(posedge clk_in) begin
    if (srst || capture) mod_q <= mod_in;
  end
endmodule

// File: rtl/dmp_prescaler.sv
module dmp_prescaler
  import dmp_pkg::*;
(
  input  logic clk_in,
  input  logic srst,
  input  logic mod_sel,
  output logic div_out,
  output logic period_tick
);
  logic wrap;
  logic half;
  logic mod_q;
  logic boundary;
  logic stretch_en;

  assign stretch_en = mod_q && half;
  assign boundary   = wrap && half;

  dmp_core45 u_core (
    .clk_in     (clk_in),
    .srst       (srst),
    .stretch_en (stretch_en),
    .wrap       (wrap)
  );

  dmp_half_stage u_half (
    .clk_in (clk_in),
    .srst   (srst),
    .adv    (wrap),
    .half   (half)
  );

  dmp_mod_latch u_mod (
    .clk_in  (clk_in),
    .srst    (srst),
    .capture (boundary),
    .mod_in  (mod_sel),
    .mod_q   (mod_q)
  );

  always_ff @(posedge clk_in) begin
    if (srst) period_tick <= 1'b0;
    else      period_tick <= boundary;
  end

  assign div_out = half;

  // Checker state: reset history and cycles since the last tick.
  logic             rst_q;
  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk_in) begin
    rst_q <= srst;
    if (srst)             gap <= '0;
    else if (period_tick) gap <= GAP_W'(1);
    else                  gap <= gap + GAP_W'(1);
  end

  // R1 and R2: tick spacing is one of the two legal ratios.
  assert_period_len_R1: assert property (@(posedge clk_in) disable iff (srst)
    period_tick |-> (gap == GAP_W'(RATIO_LOW) || gap == GAP_W'(RATIO_HI)));
  // R4: the latched modulus changes only at a period boundary.
  assert_mod_at_boundary_R4: assert property (@(posedge clk_in) disable iff (srst)
    (!$stable(mod_q) && !rst_q) |-> period_tick);
  // R7: tick lands in the low phase and lasts one cycle.
  assert_tick_low_phase_R7: assert property (@(posedge clk_in) disable iff (srst)
    period_tick |-> !div_out);
  assert_tick_single_R7: assert property (@(posedge clk_in) disable iff (srst)
    period_tick |=> !period_tick);
  // R5: outputs are quiet in the cycle after a reset edge.
  assert_reset_quiet_R5: assert property (@(posedge clk_in)
    rst_q |-> (!div_out && !period_tick));
endmodule

// File: tb/dmp_prescaler_tb_top.sv
`timescale 1ns/1ps
module dmp_prescaler_tb_top;
  logic clk_in = 1'b0;
  logic srst = 1'b1;
  logic mod_sel = 1'b0;
  logic div_out;
  logic period_tick;

  int n_cmp = 0;
  int n_bad = 0;
  bit toggling = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_in = ~clk_in;

  dmp_prescaler dut_i (
    .clk_in      (clk_in),
    .srst        (srst),
    .mod_sel     (mod_sel),
    .div_out     (div_out),
    .period_tick (period_tick)
  );

  // Reset as seen by the most recent rising edge.
  logic rst_s = 1'b1;
  always @(posedge clk_in) rst_s <= srst;

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Scoreboard: expected period lengths.
  int exp_q[$];
  int since = 0;
  int hi_cnt = 0;
  bit prev_rst = 1'b1;
  bit prev_tick = 1'b0;
  bit mod_prev = 1'b0;
  bit tog_prev = 1'b0;

  initial begin
    forever begin
      @(negedge clk_in);
      if (rst_s) begin
        exp_q.delete();
        since = 0;
        hi_cnt = 0;
        chk(!div_out && !period_tick, "R5 outputs during reset", {div_out, period_tick}, 0);
      end else begin
        // R5, R6: the modulus seen at the last reset edge sets the first period.
        if (prev_rst) exp_q.push_back(8 + int'(mod_prev));
        since++;
        if (div_out) hi_cnt++;
        if (prev_tick) chk(!period_tick, "R7 tick width", int'(period_tick), 0);
        if (since > 12) begin
          chk(1'b0, "R1 R2 no tick", since, 9);
          since = 0;
        end
        if (period_tick) begin
          chk(!div_out, "R7 tick in low phase", int'(div_out), 0);
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected tick", since, 0);
          end else begin
            int e;
            e = exp_q.pop_front();
            if (tog_prev)
              chk(since == e, "R4 period after mid-period toggles", since, e);
            else if (e == 8)
              chk(since == e, "R1 R6 period length", since, e);
            else
              chk(since == e, "R2 R6 period length", since, e);
            chk(hi_cnt == e - 4, "R3,R8 high phase length", hi_cnt, e - 4);
          end
          // The boundary edge just passed captured the modulus for the next period.
          exp_q.push_back(8 + int'(mod_prev));
          since = 0;
          hi_cnt = 0;
        end
      end
      prev_rst = rst_s;
      prev_tick = period_tick;
      mod_prev = mod_sel;
      tog_prev = toggling;
    end
  end

  // Driver: inputs change 1 ns after a rising edge.
  task automatic hold(input bit m, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk_in); #1;
      mod_sel = m;
    end
  endtask

  task automatic toggle(input int stride, input int cycles);
    toggling = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk_in); #1;
      if (i % stride == 0) mod_sel = ~mod_sel;
    end
  endtask

  task automatic do_reset(input bit m, input int cycles);
    @(posedge clk_in); #1;
    srst = 1'b1;
    mod_sel = m;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk_in); #1;
    end
    srst = 1'b0;
  endtask

  initial begin
    do_reset(1'b0, 4);
    hold(1'b0, 90);          // R1 steady
    hold(1'b1, 100);         // R2 steady
    toggle(1, 120);          // R4 fast toggles
    toggle(3, 150);
    toggle(7, 200);
    toggling = 1'b0;
    hold(1'b0, 40);
    do_reset(1'b1, 3);       // R6 with modulus 1 at release
    hold(1'b1, 60);
    hold(1'b0, 40);
    @(posedge clk_in); #1;
    done = 1'b1;
    if (n_cmp < 12) chk(1'b0, "R1 too few checks", n_cmp, 12);
    report();
  end

  initial begin
    #500000;
    if (!done) begin
      chk(1'b0, "R1 watchdog expired", 0, 1);
      report();
    end
  end
endmodule